// File: doc/BRIEF.md
# Streaming Pipelined Row Reducer

This block sums variable-length rows of integers that arrive as a single stream. Each clock cycle it can accept one value together with a small row tag and a flag that marks the final value of that row. Values from different rows may be interleaved freely. All additions go through one shared adder that has a fixed number of pipeline stages. A priority controller picks the adder's two operands every cycle. The operands can come from a pipeline result, a parked partial sum, or the first one or two entries of an arrival-ordered input queue.

Partial sums that come out of the adder and cannot be merged right away are parked in a buffer that holds one slot per tag. A row counts as complete when its closing value has arrived and its live operand count has dropped to one. At that point the sum is sitting in the parked buffer. Completed sums are released strictly in the order in which their rows first appeared at the input, one per cycle, on a registered output.

The adder depth, data width, tag width and queue depth are parameters. A tag may start a new row only after the previous row that used that tag has been output.

Top module: `rrc_top`

## Requirements
- R1: While reset is held and on the first cycles after it, `outValid` stays low.
- R2: Each output carries in `outData` the sum modulo 2^DATA_W of every value given with that row, and carries in `outRow` the row's tag.
- R3: Outputs appear in the order in which their rows' first values were accepted, even when a later row finishes earlier.
- R4: When the adder result matches the tag of a parked partial sum, these two values are the next operands, ahead of any queue operand.
- R5: Otherwise, when the adder result has the same tag as the oldest queued value, these two values are the next operands.
- R6: Otherwise, when at least two values are queued and the two oldest share a tag, both are issued together. Two queue entries are never issued when fewer than two are queued.
- R7: Otherwise, when the two oldest queued values have different tags, the oldest is issued with a zero partner. A lone queued value whose row has already closed is issued the same way.
- R8: Each completed row produces exactly one output pulse. Two consecutive valid cycles never carry the same tag.
- R9: A row made of a single value, closed on that value, outputs that value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A value is offered this cycle |
| inRow | input | ROW_W | Row tag of the offered value |
| inData | input | DATA_W | Value to accumulate |
| inLast | input | 1 | Offered value closes its row |
| outValid | output | 1 | A finished row sum is present |
| outRow | output | ROW_W | Tag of the finished row |
| outData | output | DATA_W | Sum of the finished row |

## Verification
Two functions can fall in the same cycle. The first is parking an adder result in the partial buffer while a queue pair or a zero-padded entry is issued. The second is releasing a finished row while another row's partial sums are merged. Interleaved short rows, back-to-back single-value rows and a long random run with tag reuse all force these two functions to overlap. The check is whether every released sum and its position in arrival order match a model that the bench keeps only from the values it drove.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  // Operand selection chosen by the controller, in priority order.
  typedef enum logic [2:0] {
    RULE_IDLE   = 3'd0,  // nothing issued
    RULE_PART   = 3'd1,  // adder result + parked partial of same tag
    RULE_HEADP  = 3'd2,  // adder result + oldest queued value
    RULE_PAIR   = 3'd3,  // two oldest queued values, same tag
    RULE_SINGLE = 3'd4   // oldest queued value + zero
  } rule_e;

  typedef struct packed {
    rule_e rule;
    logic  emit;
  } ctrl_s;

endpackage

// File: rtl/rrc_datapath.sv
module rrc_datapath
  import rrc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ROW_W      = 3,
  parameter int ALPHA      = 6,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic [ROW_W-1:0]         inRow,
  input  logic [DATA_W-1:0]        inData,
  input  ctrl_s                    strobe,
  input  logic [ROW_W-1:0]         emitRow,
  output logic [$clog2(FIFO_DEPTH):0] fifoCnt,
  output logic [ROW_W-1:0]         headRow,
  output logic [ROW_W-1:0]         nextRow,
  output logic                     pOutValid,
  output logic [ROW_W-1:0]         pOutRow,
  output logic [(1<<ROW_W)-1:0]    partValid,
  output logic                     outValid,
  output logic [ROW_W-1:0]         outRow,
  output logic [DATA_W-1:0]        outData
);
  localparam int ROWS = 1 << ROW_W;
  localparam int AW   = $clog2(FIFO_DEPTH);
  localparam int CW   = AW + 1;

  // input queue storage
  logic [ROW_W-1:0]  fRow  [FIFO_DEPTH];
  logic [DATA_W-1:0] fData [FIFO_DEPTH];
  logic [AW-1:0]     rdPtr, wrPtr, nxPtr;
  logic [1:0]        popN;

  // parked partial sums, one slot per tag
  logic [DATA_W-1:0] partData [ROWS];

  // adder operands
  logic              issueV;
  logic [ROW_W-1:0]  issueRow;
  logic [DATA_W-1:0] opA, opB, sum;
  logic [DATA_W-1:0] pOutData;
  logic              storePOut;

  assign nxPtr   = rdPtr + AW'(1);
  assign headRow = fRow[rdPtr];
  assign nextRow = fRow[nxPtr];

  always_comb begin
    popN     = 2'd0;
    issueV   = 1'b1;
    issueRow = fRow[rdPtr];
    opA      = fData[rdPtr];
    opB      = '0;
    unique case (strobe.rule)
      RULE_PART:   begin opA = pOutData; opB = partData[pOutRow]; issueRow = pOutRow; end
      RULE_HEADP:  begin opA = pOutData; opB = fData[rdPtr]; issueRow = pOutRow; popN = 2'd1; end
      RULE_PAIR:   begin opB = fData[nxPtr]; popN = 2'd2; end
      RULE_SINGLE: begin popN = 2'd1; end
      default:     issueV = 1'b0;
    endcase
  end

  assign sum       = opA + opB;
  assign storePOut = pOutValid && (strobe.rule != RULE_PART) && (strobe.rule != RULE_HEADP);

  always_ff @(posedge clk) begin
    if (inValid) begin
      fRow[wrPtr]  <= inRow;
      fData[wrPtr] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (inValid) wrPtr <= wrPtr + AW'(1);
      rdPtr   <= rdPtr + AW'(popN);
      fifoCnt <= fifoCnt + CW'(inValid) - CW'(popN);
    end
  end

  // adder pipeline: every stage carries valid, tag and data
  for (genvar g = 0; g < ALPHA; g++) begin : g_stage
    logic              v;
    logic [ROW_W-1:0]  r;
    logic [DATA_W-1:0] d;
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) v <= 1'b0;
        else        v <= issueV;
        r <= issueRow;
        d <= sum;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) v <= 1'b0;
        else        v <= g_stage[g-1].v;
        r <= g_stage[g-1].r;
        d <= g_stage[g-1].d;
      end
    end
  end

  assign pOutValid = g_stage[ALPHA-1].v;
  assign pOutRow   = g_stage[ALPHA-1].r;
  assign pOutData  = g_stage[ALPHA-1].d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      partValid <= '0;
    end else begin
      if (strobe.rule == RULE_PART) partValid[pOutRow] <= 1'b0;
      if (strobe.emit)              partValid[emitRow] <= 1'b0;
      if (storePOut)                partValid[pOutRow] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (storePOut) partData[pOutRow] <= pOutData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= strobe.emit;
    outRow  <= emitRow;
    outData <= partData[emitRow];
  end

endmodule

// File: rtl/rrc_ctrl.sv
module rrc_ctrl
  import rrc_pkg::*;
#(
  parameter int ROW_W      = 3,
  parameter int ALPHA      = 6,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [ROW_W-1:0]            inRow,
  input  logic                        inLast,
  input  logic [$clog2(FIFO_DEPTH):0] fifoCnt,
  input  logic [ROW_W-1:0]            headRow,
  input  logic [ROW_W-1:0]            nextRow,
  input  logic                        pOutValid,
  input  logic [ROW_W-1:0]            pOutRow,
  input  logic [(1<<ROW_W)-1:0]       partValid,
  output ctrl_s                       strobe,
  output logic [ROW_W-1:0]            emitRow
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CW    = $clog2(FIFO_DEPTH) + 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + ALPHA + ROWS + 1) + 1;

  logic [CNT_W-1:0] opCnt [ROWS];   // live operands per tag
  logic [ROWS-1:0]  active, closed;
  logic [ROW_W-1:0] order [ROWS];   // tags in first-arrival order
  logic [ROW_W-1:0] oqRd, oqWr;
  logic [ROW_W:0]   oqCnt;
  logic             reduce;
  logic [ROW_W-1:0] redRow;
  logic [ROWS-1:0]  incVec, decVec;
  logic             startRow;

  always_comb begin
    strobe.rule = RULE_IDLE;
    if (pOutValid && partValid[pOutRow])
      strobe.rule = RULE_PART;
    else if (pOutValid && fifoCnt != '0 && headRow == pOutRow)
      strobe.rule = RULE_HEADP;
    else if (fifoCnt >= CW'(2) && headRow == nextRow)
      strobe.rule = RULE_PAIR;
    else if (fifoCnt >= CW'(2))
      strobe.rule = RULE_SINGLE;
    else if (fifoCnt == CW'(1) && closed[headRow])
      strobe.rule = RULE_SINGLE;
  end

  assign emitRow     = order[oqRd];
  assign strobe.emit = (oqCnt != '0) && closed[emitRow] &&
                       (opCnt[emitRow] == CNT_W'(1)) && partValid[emitRow];

  assign reduce   = (strobe.rule == RULE_PART) || (strobe.rule == RULE_HEADP) ||
                    (strobe.rule == RULE_PAIR);
  assign redRow   = (strobe.rule == RULE_PAIR) ? headRow : pOutRow;
  assign startRow = inValid && !active[inRow];

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      incVec[r] = inValid && (inRow == ROW_W'(r));
      decVec[r] = reduce && (redRow == ROW_W'(r));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      closed <= '0;
      oqRd   <= '0;
      oqWr   <= '0;
      oqCnt  <= '0;
      for (int r = 0; r < ROWS; r++) opCnt[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++)
        opCnt[r] <= opCnt[r] + CNT_W'(incVec[r]) - CNT_W'(decVec[r]);
      if (strobe.emit) begin
        opCnt[emitRow]  <= '0;
        active[emitRow] <= 1'b0;
        closed[emitRow] <= 1'b0;
        oqRd            <= oqRd + ROW_W'(1);
      end
      if (startRow) begin
        active[inRow] <= 1'b1;
        order[oqWr]   <= inRow;
        oqWr          <= oqWr + ROW_W'(1);
      end
      if (inValid && inLast) closed[inRow] <= 1'b1;
      oqCnt <= oqCnt + (ROW_W+1)'(startRow) - (ROW_W+1)'(strobe.emit);
    end
  end

endmodule

// File: rtl/rrc_top.sv
module rrc_top
  import rrc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ROW_W      = 3,
  parameter int ALPHA      = 6,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [ROW_W-1:0]  outRow,
  output logic [DATA_W-1:0] outData
);
  ctrl_s                        strobe;
  logic [ROW_W-1:0]             emitRow;
  logic [$clog2(FIFO_DEPTH):0]  fifoCnt;
  logic [ROW_W-1:0]             headRow, nextRow, pOutRow;
  logic                         pOutValid;
  logic [(1<<ROW_W)-1:0]        partValid;

  rrc_ctrl #(.ROW_W(ROW_W), .ALPHA(ALPHA), .FIFO_DEPTH(FIFO_DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inRow(inRow), .inLast(inLast),
    .fifoCnt(fifoCnt), .headRow(headRow), .nextRow(nextRow),
    .pOutValid(pOutValid), .pOutRow(pOutRow), .partValid(partValid),
    .strobe(strobe), .emitRow(emitRow)
  );

  rrc_datapath #(.DATA_W(DATA_W), .ROW_W(ROW_W), .ALPHA(ALPHA), .FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inRow(inRow), .inData(inData),
    .strobe(strobe), .emitRow(emitRow),
    .fifoCnt(fifoCnt), .headRow(headRow), .nextRow(nextRow),
    .pOutValid(pOutValid), .pOutRow(pOutRow), .partValid(partValid),
    .outValid(outValid), .outRow(outRow), .outData(outData)
  );

endmodule

// File: rtl/rrc_chk.sv
module rrc_chk
  import rrc_pkg::*;
#(
  parameter int ROW_W      = 3,
  parameter int FIFO_DEPTH = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input rule_e                       rule,
  input logic                        pOutValid,
  input logic [ROW_W-1:0]            pOutRow,
  input logic [(1<<ROW_W)-1:0]       partValid,
  input logic [$clog2(FIFO_DEPTH):0] fifoCnt,
  input logic [ROW_W-1:0]            headRow,
  input logic [ROW_W-1:0]            nextRow,
  input logic                        outValid,
  input logic [ROW_W-1:0]            outRow
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !outValid);

  // R4
  part_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pOutValid && partValid[pOutRow]) |-> rule == RULE_PART);

  // R5
  head_pout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pOutValid && !partValid[pOutRow] && fifoCnt != '0 && headRow == pOutRow)
      |-> rule == RULE_HEADP);

  // R6
  pair_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rule == RULE_PAIR |-> (fifoCnt >= CW'(2) && headRow == nextRow));

  // R7
  single_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoCnt >= CW'(2) && headRow != nextRow &&
     !(pOutValid && (partValid[pOutRow] || headRow == pOutRow)))
      |-> rule == RULE_SINGLE);

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !(outValid && outRow == $past(outRow)));

endmodule

bind rrc_top rrc_chk #(.ROW_W(ROW_W), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rule(strobe.rule),
  .pOutValid(pOutValid), .pOutRow(pOutRow), .partValid(partValid),
  .fifoCnt(fifoCnt), .headRow(headRow), .nextRow(nextRow),
  .outValid(outValid), .outRow(outRow)
);

// File: tb/rrc_top_tb_top.sv
`timescale 1ns/1ps
module rrc_top_tb_top;
  localparam int DATA_W = 16;
  localparam int ROW_W  = 3;
  localparam int ROWS   = 1 << ROW_W;
  localparam int MAXEXP = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inValid = 1'b0;
  logic [ROW_W-1:0]  inRow = '0;
  logic [DATA_W-1:0] inData = '0;
  logic              inLast = 1'b0;
  logic              outValid;
  logic [ROW_W-1:0]  outRow;
  logic [DATA_W-1:0] outData;

  always #2 clk = ~clk;  // 250 MHz

  rrc_top #(.DATA_W(DATA_W), .ROW_W(ROW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inRow(inRow), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outRow(outRow), .outData(outData)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  int nExp = 0, nGot = 0;
  int expRow [MAXEXP];
  logic [DATA_W-1:0] expSum [MAXEXP];
  bit busy [ROWS];
  bit open [ROWS];
  int seqOf [ROWS];
  bit done = 0;

  function automatic logic [DATA_W-1:0] addWrap(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic pushVal(int r, logic [DATA_W-1:0] v, bit last);
    @(negedge clk);
    inValid = 1'b1; inRow = ROW_W'(r); inData = v; inLast = last;
    if (!open[r]) begin
      open[r] = 1; busy[r] = 1; seqOf[r] = nExp;
      expRow[nExp] = r; expSum[nExp] = '0; nExp++;
    end
    expSum[seqOf[r]] = addWrap(expSum[seqOf[r]], v);
    if (last) open[r] = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    idle(1);
    while (nGot < nExp && guard < 2000) begin idle(1); guard++; end
    check(nGot == nExp, "R8 every row output", nGot, nExp);
  endtask

  // output monitor, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && outValid) begin
      if (nGot >= nExp) begin
        check(0, "R8 unexpected output", int'(outRow), -1);
      end else begin
        check(int'(outRow) == expRow[nGot], "R3 order/tag", int'(outRow), expRow[nGot]);
        check(outData == expSum[nGot], "R2 row sum", int'(outData), int'(expSum[nGot]));
        busy[outRow] = 0;
        nGot++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      vectors++; miscompares++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", nGot, nExp);
      finishRun();
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin busy[r] = 0; open[r] = 0; seqOf[r] = 0; end
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 idle in reset", int'(outValid), 0);
    rst_n = 1'b1;
    idle(3);
    check(outValid == 1'b0, "R1 idle after reset", int'(outValid), 0);

    // R9 and R7 (lone closed entry flushed with zero)
    pushVal(2, 16'h1234, 1);
    drain();

    // R6, R5, R4: one row, consecutive values
    pushVal(1, 16'd1, 0); pushVal(1, 16'd2, 0); pushVal(1, 16'd3, 0);
    pushVal(1, 16'd4, 0); pushVal(1, 16'd5, 1);
    drain();

    // R7: interleaved rows force zero-padded issues
    pushVal(3, 16'd10, 0); pushVal(4, 16'd20, 0); pushVal(3, 16'd30, 0);
    pushVal(4, 16'd40, 0); pushVal(3, 16'd50, 1); pushVal(4, 16'd60, 1);
    drain();

    // R3: later row closes first, results still in arrival order
    pushVal(5, 16'd7, 0); pushVal(6, 16'd9, 1);
    idle(20);
    pushVal(5, 16'd8, 1);
    drain();

    // R3, R9: burst of single-value rows on all tags
    for (int r = 0; r < ROWS; r++) pushVal(r, DATA_W'(100 + r), 1);
    drain();

    // R2: wrap-around of the sum
    pushVal(0, 16'hFFFF, 0); pushVal(0, 16'h0002, 1);
    drain();

    // constrained random traffic with tag reuse
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(ROWS - 1));
      if ($urandom_range(1) == 0 || nExp >= MAXEXP - 2) idle(1);
      else if (open[r]) pushVal(r, DATA_W'($urandom), $urandom_range(3) == 0);
      else if (!busy[r]) pushVal(r, DATA_W'($urandom), $urandom_range(3) == 0);
      else idle(1);
    end
    for (int r = 0; r < ROWS; r++)
      if (open[r]) pushVal(r, DATA_W'($urandom), 1);
    drain();

    idle(10);
    done = 1;
    finishRun();
  end

endmodule